// File: doc/BRIEF.md
# Multi-Mode Variable-Length Timer Counter

This block is the counting core of a general-purpose timer. A selectable event source is divided by 1, 2, 4 or 8 to form a count tick. Each tick advances a counter whose usable length can be cut to 8, 10, 12 or 16 bits. Four operating modes are offered. Halt freezes everything. Up counts from zero to a period value supplied on the `latch0` input and wraps. Free-running counts to the length maximum and wraps. Up/down climbs to the period value and walks back down to zero. A rollover flag records each wrap (or each return to zero in up/down) until software clears it, and it raises an interrupt line when enabled.

Software drives a single control write port. Bits [1:0] select the mode (00 halt, 01 up, 10 free, 11 up/down). Bits [3:2] select the divider. Bits [5:4] select the source. Bits [7:6] select the length. Bit 8 is a self-clearing clear command. Bit 9 is the interrupt enable and bit 10 is the rollover flag. The effective period in up and up/down mode is the smaller of `latch0` and the length maximum.

The count direction is held by a two-state machine. In state RISE (`dir_o`=0) the counter is climbing. In state FALL (`dir_o`=1) it is descending. The machine has these transitions:
- TURN_AT_TOP: RISE to FALL on a tick in up/down mode when the count is at or above the period.
- TURN_AT_ZERO: FALL to RISE on a tick in up/down mode when the count is zero.
- FORCE_RISE: any state to RISE on a clear, or on a tick in up or free mode.

Top module: `tmr_multimode`

## Requirements
- R1: After reset the counter is 0, the direction is up (`dir_o`=0), `tick_o` is 0 and `ctl_rdata` reads 0 (halt mode, divider /1, external rising source, 16-bit length, interrupt disabled, flag clear).
- R2: In halt mode (bits[1:0]=00) the source events are ignored: the counter, the direction and the prescaler hold, and `tick_o` stays 0.
- R3: In up mode (01) each tick adds one until the count reaches min(`latch0`, length maximum). The next tick wraps the count to 0 and sets the flag. A count already above that period wraps to 0 on its next tick.
- R4: In free mode (10) each tick adds one up to the length maximum. The next tick wraps the count to 0 and sets the flag.
- R5: The length field bits[7:6] sets the maximum: 00 gives 0xFFFF, 01 gives 0x0FFF, 10 gives 0x03FF and 11 gives 0x00FF.
- R6: In up/down mode (11) the counter climbs to the period, then descends to 0, then climbs again; `dir_o` is 1 while it descends. The flag is set when a descending tick reaches 0. With a period of 0 the counter stays at 0 and sets no flag.
- R7: The divider bits[3:2] codes 00/01/10/11 produce one tick per 1/2/4/8 selected source events. The counter changes only on a tick, and `tick_o` is 1 for the single cycle in which the advanced count is first visible.
- R8: The source bits[5:4] select the event: 00 is each rising edge of `ext_clk_lvl`, 01 is each cycle with `int_a_en` high, 10 is each cycle with `int_b_en` high, and 11 is each falling edge of `ext_clk_lvl`. The unselected sources have no effect.
- R9: A write with bit 8 set zeroes the counter and the prescaler, forces the direction up and counts nothing in that cycle. The other written fields take effect, and bit 8 always reads back 0.
- R10: Every write loads the flag from bit 10. A rollover in the same cycle wins and leaves the flag set. Without a write the flag stays set, and `irq_o` is high exactly when the flag and the enable (bit 9) are both 1.
- R11: `ctl_rdata` returns mode, divider, source, length, enable and flag at the bit positions written, with bit 8 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_lvl | input | 1 | Synchronous level of the external timer clock; its edges are events |
| int_a_en | input | 1 | First internal clock-enable pulse |
| int_b_en | input | 1 | Second internal clock-enable pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 11 | Control register write data |
| latch0 | input | CNT_W | Period value for up and up/down modes |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Count direction, 1 while descending |
| tick_o | output | 1 | One-cycle strobe marking a counter advance |
| ctl_rdata | output | 11 | Control register read data |
| ovf_flag_o | output | 1 | Rollover flag |
| ovf_en_o | output | 1 | Rollover interrupt enable |
| irq_o | output | 1 | Rollover interrupt request |

## Verification
The hardest conditions to reach are the length maximum in 16-bit free mode and the cycle where a rollover coincides with a software write that clears the flag. The bench reaches the first by holding `int_a_en` high with divider /1 for 65,536 cycles. It reaches the second by placing a flag-clearing write on the same edge as the wrapping pulse. The up/down turning points are stepped one tick at a time, including a period of zero. A mode switch with the count above the new period is also covered. A behavioural model tracks every cycle of all of this.

// File: rtl/tmr_multimode_pkg.sv
package tmr_multimode_pkg;

    localparam int CTL_W     = 11;
    localparam int F_MODE_LO = 0;
    localparam int F_DIV_LO  = 2;
    localparam int F_SRC_LO  = 4;
    localparam int F_LEN_LO  = 6;
    localparam int F_CLR     = 8;
    localparam int F_IE      = 9;
    localparam int F_FLAG    = 10;

    typedef enum logic [1:0] {
        MODE_HALT   = 2'b00,
        MODE_UP     = 2'b01,
        MODE_FREE   = 2'b10,
        MODE_UPDOWN = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        SRC_EXT_RISE = 2'b00,
        SRC_INT_A    = 2'b01,
        SRC_INT_B    = 2'b10,
        SRC_EXT_FALL = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        LEN_16 = 2'b00,
        LEN_12 = 2'b01,
        LEN_10 = 2'b10,
        LEN_8  = 2'b11
    } len_e;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } dir_e;

    typedef struct packed {
        logic       ovf_flag;
        logic       ovf_en;
        len_e       len;
        src_e       src;
        logic [1:0] div;
        mode_e      mode;
    } ctl_t;

    function automatic int len_bits(len_e l);
        int b;
        unique case (l)
            LEN_16: b = 16;
            LEN_12: b = 12;
            LEN_10: b = 10;
            LEN_8:  b = 8;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tmr_multimode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ext_lvl,
    input  logic int_a_en,
    input  logic int_b_en,
    input  src_e sel,
    output logic pulse
);

    logic ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= 1'b0;
        end else begin
            ext_q <= ext_lvl;
        end
    end

    always_comb begin
        unique case (sel)
            SRC_EXT_RISE: pulse = ext_lvl & ~ext_q;
            SRC_INT_A:    pulse = int_a_en;
            SRC_INT_B:    pulse = int_b_en;
            SRC_EXT_FALL: pulse = ~ext_lvl & ext_q;
        endcase
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              pulse,
    input  logic [CODE_W-1:0] code,
    output logic              tick_c,
    output logic              tick_q
);

    localparam int PRE_W = (1 << CODE_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // low bits that must all be one before an event becomes a tick
    assign mask   = PRE_W'((32'd1 << code) - 32'd1);
    assign tick_c = run & pulse & ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick_c & ~clr;
            if (clr) begin
                pre_q <= '0;
            end else if (run && pulse) begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_multimode_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  mode_e            mode,
    input  len_e             len,
    input  logic [CNT_W-1:0] lat0,
    output logic [CNT_W-1:0] cnt,
    output logic             dir,
    output logic             wrap_ev
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    dir_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   one_sh;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] top;

    always_comb begin
        one_sh = (CNT_W+1)'(1) << len_bits(len);
        lim    = CNT_W'(one_sh - (CNT_W+1)'(1));
        top    = (lat0 < lim) ? lat0 : lim;
    end

    // next-state and next-count logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wrap_ev = 1'b0;
        if (clr) begin
            state_d = DIR_RISE;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (mode)
                MODE_HALT: begin
                    cnt_d = cnt_q;
                end
                MODE_UP: begin
                    state_d = DIR_RISE;
                    if (cnt_q >= top) begin
                        cnt_d   = '0;
                        wrap_ev = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                MODE_FREE: begin
                    state_d = DIR_RISE;
                    if (cnt_q >= lim) begin
                        cnt_d   = '0;
                        wrap_ev = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                MODE_UPDOWN: begin
                    if (top == '0) begin
                        state_d = DIR_RISE;
                        cnt_d   = '0;
                    end else begin
                        unique case (state_q)
                            DIR_RISE: begin
                                if (cnt_q >= top) begin
                                    state_d = DIR_FALL;
                                    cnt_d   = cnt_q - ONE;
                                    wrap_ev = (cnt_q == ONE);
                                end else begin
                                    cnt_d = cnt_q + ONE;
                                end
                            end
                            DIR_FALL: begin
                                if (cnt_q == '0) begin
                                    state_d = DIR_RISE;
                                    cnt_d   = ONE;
                                end else begin
                                    cnt_d   = cnt_q - ONE;
                                    wrap_ev = (cnt_q == ONE);
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIR_RISE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        cnt = cnt_q;
        dir = (state_q == DIR_FALL);
    end

endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs
    import tmr_multimode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             wrap_ev,
    output ctl_t             ctl,
    output logic             clr,
    output logic [CTL_W-1:0] rdata
);

    ctl_t ctl_q;

    assign clr = we & wdata[F_CLR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (we) begin
                ctl_q.mode   <= mode_e'(wdata[F_MODE_LO +: 2]);
                ctl_q.div    <= wdata[F_DIV_LO +: 2];
                ctl_q.src    <= src_e'(wdata[F_SRC_LO +: 2]);
                ctl_q.len    <= len_e'(wdata[F_LEN_LO +: 2]);
                ctl_q.ovf_en <= wdata[F_IE];
            end
            if (wrap_ev) begin
                ctl_q.ovf_flag <= 1'b1;
            end else if (we) begin
                ctl_q.ovf_flag <= wdata[F_FLAG];
            end
        end
    end

    always_comb begin
        ctl                   = ctl_q;
        rdata                 = '0;
        rdata[F_MODE_LO +: 2] = ctl_q.mode;
        rdata[F_DIV_LO +: 2]  = ctl_q.div;
        rdata[F_SRC_LO +: 2]  = ctl_q.src;
        rdata[F_LEN_LO +: 2]  = ctl_q.len;
        rdata[F_IE]           = ctl_q.ovf_en;
        rdata[F_FLAG]         = ctl_q.ovf_flag;
    end

endmodule

// File: rtl/tmr_multimode.sv
module tmr_multimode
    import tmr_multimode_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_lvl,
    input  logic             int_a_en,
    input  logic             int_b_en,
    input  logic             ctl_we,
    input  logic [10:0]      ctl_wdata,
    input  logic [CNT_W-1:0] latch0,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             tick_o,
    output logic [10:0]      ctl_rdata,
    output logic             ovf_flag_o,
    output logic             ovf_en_o,
    output logic             irq_o
);

    ctl_t ctl;
    logic clr;
    logic wrap_ev;
    logic pulse;
    logic tick_c;
    logic run;

    tmr_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl_we),
        .wdata   (ctl_wdata),
        .wrap_ev (wrap_ev),
        .ctl     (ctl),
        .clr     (clr),
        .rdata   (ctl_rdata)
    );

    tmr_src_sel u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_lvl  (ext_clk_lvl),
        .int_a_en (int_a_en),
        .int_b_en (int_b_en),
        .sel      (ctl.src),
        .pulse    (pulse)
    );

    assign run = (ctl.mode != MODE_HALT);

    tmr_prescale #(.CODE_W(CODE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .run    (run),
        .pulse  (pulse),
        .code   (CODE_W'(ctl.div)),
        .tick_c (tick_c),
        .tick_q (tick_o)
    );

    tmr_count_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .tick    (tick_c),
        .mode    (ctl.mode),
        .len     (ctl.len),
        .lat0    (latch0),
        .cnt     (cnt_o),
        .dir     (dir_o),
        .wrap_ev (wrap_ev)
    );

    assign ovf_flag_o = ctl.ovf_flag;
    assign ovf_en_o   = ctl.ovf_en;
    assign irq_o      = ctl.ovf_flag & ctl.ovf_en;

endmodule

// File: rtl/tmr_multimode_chk.sv
module tmr_multimode_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [10:0]      ctl_wdata,
    input logic [CNT_W-1:0] cnt_o,
    input logic             dir_o,
    input logic             tick_o,
    input logic [10:0]      ctl_rdata
);

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt_o == '0 && !dir_o && ctl_rdata == '0));

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[1:0] == 2'b00 && !ctl_we) |=> ($stable(cnt_o) && $stable(dir_o) && !tick_o));

    // R7
    count_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && !$past(ctl_we)) |-> $stable(cnt_o));

    // R9
    clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[8]) |=> (cnt_o == '0 && !dir_o && !tick_o && !ctl_rdata[8]));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[10] && !ctl_we) |=> ctl_rdata[10]);

endmodule

bind tmr_multimode tmr_multimode_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .cnt_o     (cnt_o),
    .dir_o     (dir_o),
    .tick_o    (tick_o),
    .ctl_rdata (ctl_rdata)
);

// File: tb/tmr_multimode_tb.sv
`timescale 1ns/1ps
module tmr_multimode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_lvl = 1'b0;
    logic        int_a_en = 1'b0;
    logic        int_b_en = 1'b0;
    logic        ctl_we = 1'b0;
    logic [10:0] ctl_wdata = '0;
    logic [15:0] latch0 = '0;
    logic [15:0] cnt_o;
    logic        dir_o, tick_o, ovf_flag_o, ovf_en_o, irq_o;
    logic [10:0] ctl_rdata;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    tmr_multimode u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_lvl(ext_clk_lvl), .int_a_en(int_a_en),
        .int_b_en(int_b_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .latch0(latch0),
        .cnt_o(cnt_o), .dir_o(dir_o), .tick_o(tick_o), .ctl_rdata(ctl_rdata),
        .ovf_flag_o(ovf_flag_o), .ovf_en_o(ovf_en_o), .irq_o(irq_o)
    );

    // behavioural reference model
    int m_cnt, m_pre, m_mode, m_div, m_src, m_len;
    bit m_dir, m_flag, m_ie, m_tick, m_extq;

    always @(posedge clk) begin
        bit pulse, ev, tk;
        int maxv, topv, bits;
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_mode = 0; m_div = 0; m_src = 0; m_len = 0;
            m_dir = 0; m_flag = 0; m_ie = 0; m_tick = 0; m_extq = 0;
        end else begin
            case (m_src)
                0: pulse = ext_clk_lvl && !m_extq;
                1: pulse = int_a_en;
                2: pulse = int_b_en;
                default: pulse = !ext_clk_lvl && m_extq;
            endcase
            case (m_len)
                0: bits = 16;
                1: bits = 12;
                2: bits = 10;
                default: bits = 8;
            endcase
            maxv = (1 << bits) - 1;
            topv = (int'(latch0) < maxv) ? int'(latch0) : maxv;
            ev = 0; tk = 0;
            if (ctl_we && ctl_wdata[8]) begin
                m_cnt = 0; m_pre = 0; m_dir = 0;
            end else if (m_mode != 0 && pulse) begin
                tk = ((m_pre % (1 << m_div)) == ((1 << m_div) - 1));
                m_pre = (m_pre + 1) % 8;
                if (tk) begin
                    if (m_mode == 1) begin
                        m_dir = 0;
                        if (m_cnt >= topv) begin m_cnt = 0; ev = 1; end
                        else m_cnt++;
                    end else if (m_mode == 2) begin
                        m_dir = 0;
                        if (m_cnt >= maxv) begin m_cnt = 0; ev = 1; end
                        else m_cnt++;
                    end else if (topv == 0) begin
                        m_cnt = 0; m_dir = 0;
                    end else if (!m_dir) begin
                        if (m_cnt >= topv) begin m_dir = 1; m_cnt--; ev = (m_cnt == 0); end
                        else m_cnt++;
                    end else begin
                        if (m_cnt == 0) begin m_dir = 0; m_cnt = 1; end
                        else begin m_cnt--; ev = (m_cnt == 0); end
                    end
                end
            end
            m_tick = tk;
            if (ctl_we) begin
                m_mode = int'(ctl_wdata[1:0]);
                m_div  = int'(ctl_wdata[3:2]);
                m_src  = int'(ctl_wdata[5:4]);
                m_len  = int'(ctl_wdata[7:6]);
                m_ie   = ctl_wdata[9];
                m_flag = ctl_wdata[10];
            end
            if (ev) m_flag = 1;
            m_extq = ext_clk_lvl;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        int exp_rd;
        if (rst_n && !done) begin
            exp_rd = (int'(m_flag) << 10) | (int'(m_ie) << 9) | (m_len << 6) |
                     (m_src << 4) | (m_div << 2) | m_mode;
            total++;
            if (int'(cnt_o) != m_cnt || dir_o != m_dir || tick_o != m_tick ||
                int'(ctl_rdata) != exp_rd || irq_o != (m_flag && m_ie) ||
                ovf_flag_o != m_flag || ovf_en_o != m_ie) begin
                bad++;
                $display("FAIL %s model: cnt=%0d dir=%0b tick=%0b rd=%h irq=%0b exp cnt=%0d dir=%0b tick=%0b rd=%h irq=%0b",
                         cur_req, cnt_o, dir_o, tick_o, ctl_rdata, irq_o,
                         m_cnt, m_dir, m_tick, exp_rd[10:0], m_flag && m_ie);
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [10:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_tick(logic [10:0] d);
        ctl_we = 1'b1; ctl_wdata = d; int_a_en = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0; int_a_en = 1'b0;
    endtask

    task automatic pa(int n);
        int_a_en = 1'b1;
        repeat (n) @(negedge clk);
        int_a_en = 1'b0;
    endtask

    task automatic ext_pulses(int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_lvl = 1'b1; @(negedge clk);
            ext_clk_lvl = 1'b0; @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cnt", int'(cnt_o), 0);
        check("R1 rdata", int'(ctl_rdata), 0);
        check("R1 tick", int'(tick_o), 0);
        check("R1 irq", int'(irq_o), 0);

        // R8 source select
        cur_req = "R8";
        wr(11'h112); pa(5);
        check("R8 int_a", int'(cnt_o), 5);
        int_b_en = 1'b1; repeat (4) @(negedge clk); int_b_en = 1'b0;
        check("R8 int_b ignored", int'(cnt_o), 5);
        wr(11'h122); int_b_en = 1'b1; repeat (3) @(negedge clk); int_b_en = 1'b0;
        check("R8 int_b", int'(cnt_o), 3);
        wr(11'h102); ext_pulses(4);
        check("R8 ext rise", int'(cnt_o), 4);
        wr(11'h132); ext_pulses(4);
        check("R8 ext fall", int'(cnt_o), 4);

        // R7 divider
        cur_req = "R7";
        wr(11'h11A); pa(20);
        check("R7 div4", int'(cnt_o), 5);
        wr(11'h11E); pa(16);
        check("R7 div8", int'(cnt_o), 2);
        wr(11'h116); pa(6);
        check("R7 div2", int'(cnt_o), 3);
        wr(11'h11A); pa(4);
        check("R7 tick strobe", int'(tick_o), 1);
        check("R7 cnt at strobe", int'(cnt_o), 1);
        @(negedge clk);
        check("R7 strobe one cycle", int'(tick_o), 0);

        // R2 halt
        cur_req = "R2";
        wr(11'h112); pa(3);
        wr(11'h010); pa(5);
        check("R2 halt cnt", int'(cnt_o), 3);
        check("R2 halt tick", int'(tick_o), 0);

        // R3 up mode
        cur_req = "R3";
        latch0 = 16'd5;
        wr(11'h111); pa(5);
        check("R3 at period", int'(cnt_o), 5);
        check("R3 flag before wrap", int'(ctl_rdata[10]), 0);
        pa(1);
        check("R3 wrap", int'(cnt_o), 0);
        check("R3 flag", int'(ctl_rdata[10]), 1);
        wr(11'h112); pa(9);
        wr(11'h011); pa(1);
        check("R3 above period", int'(cnt_o), 0);
        latch0 = 16'd300;
        wr(11'h1D1); pa(256);
        check("R3 period capped by length", int'(cnt_o), 0);

        // R4 / R5 free mode and lengths
        cur_req = "R5";
        wr(11'h1D2); pa(255);
        check("R5 8-bit max", int'(cnt_o), 255);
        check("R4 no flag at max", int'(ctl_rdata[10]), 0);
        pa(1);
        check("R4 8-bit wrap", int'(cnt_o), 0);
        check("R4 flag", int'(ctl_rdata[10]), 1);
        wr(11'h192); pa(1023);
        check("R5 10-bit max", int'(cnt_o), 1023);
        pa(1);
        check("R5 10-bit wrap", int'(cnt_o), 0);
        wr(11'h152); pa(4095);
        check("R5 12-bit max", int'(cnt_o), 4095);
        pa(1);
        check("R5 12-bit wrap", int'(cnt_o), 0);
        cur_req = "R4";
        wr(11'h112); pa(65535);
        check("R4 16-bit max", int'(cnt_o), 65535);
        pa(1);
        check("R4 16-bit wrap", int'(cnt_o), 0);
        check("R4 16-bit flag", int'(ctl_rdata[10]), 1);

        // R6 up/down
        cur_req = "R6";
        latch0 = 16'd3;
        wr(11'h113); pa(3);
        check("R6 top", int'(cnt_o), 3);
        check("R6 dir up", int'(dir_o), 0);
        pa(1);
        check("R6 descend", int'(cnt_o), 2);
        check("R6 dir down", int'(dir_o), 1);
        pa(2);
        check("R6 zero", int'(cnt_o), 0);
        check("R6 flag at zero", int'(ctl_rdata[10]), 1);
        pa(1);
        check("R6 reclimb", int'(cnt_o), 1);
        check("R6 dir up again", int'(dir_o), 0);
        latch0 = 16'd0;
        wr(11'h113); pa(4);
        check("R6 zero period cnt", int'(cnt_o), 0);
        check("R6 zero period flag", int'(ctl_rdata[10]), 0);

        // R9 clear
        cur_req = "R9";
        latch0 = 16'd3;
        wr(11'h113); pa(4);
        wr(11'h113);
        check("R9 cnt", int'(cnt_o), 0);
        check("R9 dir", int'(dir_o), 0);
        check("R9 reads 0", int'(ctl_rdata[8]), 0);
        wr(11'h11A); pa(2);
        wr(11'h11A); pa(3);
        check("R9 prescaler reset", int'(cnt_o), 0);
        pa(1);
        check("R9 prescaler restart", int'(cnt_o), 1);

        // R10 flag and interrupt
        cur_req = "R10";
        latch0 = 16'd2;
        wr(11'h311); pa(3);
        check("R10 flag", int'(ovf_flag_o), 1);
        check("R10 irq", int'(irq_o), 1);
        wr(11'h211);
        check("R10 flag cleared", int'(ovf_flag_o), 0);
        check("R10 irq cleared", int'(irq_o), 0);
        pa(2);
        wr_tick(11'h211);
        check("R10 wrap wins", int'(ovf_flag_o), 1);
        check("R10 wrap cnt", int'(cnt_o), 0);
        wr(11'h411);
        check("R10 irq disabled", int'(irq_o), 0);
        check("R10 flag kept", int'(ovf_flag_o), 1);

        // R11 readback
        cur_req = "R11";
        wr(11'h7FF);
        check("R11 rdata", int'(ctl_rdata), 32'h6FF);
        check("R11 enable out", int'(ovf_en_o), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule